// File: doc/BRIEF.md
# Accumulator ALU with Per-Flag Write Enables

This block is the purely combinational arithmetic and logic unit of a small accumulator CPU. A 4-bit operation code selects one of several operations. Most of them work on two byte-wide operands and a carry input. Two of them work on 16-bit register pairs: a full pair add, and a pair plus a sign-extended byte offset. The block returns a byte result and a pair result, each with its own write enable. It also returns four condition flags: zero, subtract, half-carry and carry.

Every flag has its own write enable. The register file stores only the flags whose enable is high and keeps the rest. This is how an operation leaves carry or zero unchanged. The compare operation updates all four flags but drops its difference, so the accumulator keeps its value. Unused operation codes pass the operands through and request no writes at all.

Top module: `acc_alu`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) give result = a + b, plus carry_in for code 1 only, modulo 256. Zero is set when that byte is 0, subtract is 0, half-carry is the carry out of bit 3 (carry_in included), and carry is the carry out of bit 7. All four flag enables are high and result_we is high.
- R2: Codes 2 (subtract) and 3 (subtract with carry) give result = a - b, minus carry_in for code 3 only, modulo 256. Zero follows the byte, subtract is 1, half-carry is set when the low nibble of a is smaller than the low nibble of b plus the borrow-in, and carry is set when a is smaller than b plus the borrow-in. All four enables are high and result_we is high.
- R3: Code 7 (compare) sets all four flags exactly as code 2 does, with all enables high. result_we is 0 and result equals a.
- R4: Code 4 (AND) gives a & b, zero by result, subtract 0, half-carry forced to 1, carry 0. All enables are high and result_we is high.
- R5: Codes 5 (XOR) and 6 (OR) give a ^ b and a | b, zero by result, subtract, half-carry and carry all 0. All enables are high and result_we is high.
- R6: Codes 8 (increment) and 9 (decrement) give a + 1 and a - 1. Zero follows the result. Subtract is 0 for increment and 1 for decrement. Half-carry is set when the low nibble of a is 0xF (increment) or 0x0 (decrement). The carry enable is 0 and carry_in has no effect on any output.
- R7: Code 10 (pair add) gives pair_result = pair_a + pair_b modulo 65536 with pair_we high. Carry is bit 16 of the full sum, half-carry is the carry out of bit 11, and subtract is 0. The zero enable is 0, and the carry, half-carry and subtract enables are 1.
- R8: Code 11 (pair plus offset) gives pair_result = pair_a + sign-extended b with pair_we high. Half-carry and carry are the carry out of bit 3 and bit 7 of the unsigned add of the low byte of pair_a and b. Zero and subtract are forced to 0, and all four enables are high.
- R9: Codes 12 to 15 give result = a and pair_result = pair_a, with result_we, pair_we and all four flag enables low.
- R10: A flag whose enable is low reads as 0. result_we is high only for codes 0 to 6, 8 and 9, and pair_we only for codes 10 and 11. result equals a for codes 10 and 11, and pair_result equals pair_a for codes 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand, or the signed offset for code 11 |
| carry_in | input | 1 | Current carry flag |
| pair_a | input | 16 | First register-pair operand |
| pair_b | input | 16 | Second register-pair operand |
| result | output | 8 | Byte result |
| result_we | output | 1 | Byte result should be written |
| pair_result | output | 16 | Register-pair result |
| pair_we | output | 1 | Pair result should be written |
| flag_z | output | 1 | Zero flag value |
| flag_n | output | 1 | Subtract flag value |
| flag_h | output | 1 | Half-carry flag value |
| flag_c | output | 1 | Carry flag value |
| wr_z | output | 1 | Zero flag write enable |
| wr_n | output | 1 | Subtract flag write enable |
| wr_h | output | 1 | Half-carry flag write enable |
| wr_c | output | 1 | Carry flag write enable |

## Verification
The bench builds the block twice: once with the default byte width and subtract by two's-complement inversion, and once with SUB_BY_INVERT set to 0, which selects the direct-difference subtractor. Running both checks that the two generate variants agree on every borrow and half-borrow. This matters most at the corners: 0x00 minus 0xFF with a borrow-in, equal nibbles with a borrow-in, and wrap of the pair adds at bits 11 and 16.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADC   = 4'd1,
      OP_SUB   = 4'd2,
      OP_SBC   = 4'd3,
      OP_AND   = 4'd4,
      OP_XOR   = 4'd5,
      OP_OR    = 4'd6,
      OP_CMP   = 4'd7,
      OP_INC   = 4'd8,
      OP_DEC   = 4'd9,
      OP_ADDW  = 4'd10,
      OP_ADDSP = 4'd11
   } alu_op_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_XOR = 2'd1,
      LG_OR  = 2'd2
   } logic_sel_e;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } alu_flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int WIDTH         = 8,
   parameter int NIBBLE        = 4,
   parameter bit SUB_BY_INVERT = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             c_out,
   output logic             h_out
);

   generate
      if (SUB_BY_INVERT) begin : g_invert
         // a - b - cin == a + ~b + ~cin ; borrow is the inverted carry
         logic [WIDTH-1:0]  b_eff;
         logic              c_eff;
         logic [WIDTH:0]    full;
         logic [NIBBLE:0]   low;

         always_comb begin
            b_eff = sub ? ~b : b;
            c_eff = sub ? ~cin : cin;
            full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
            low   = {1'b0, a[NIBBLE-1:0]} + {1'b0, b_eff[NIBBLE-1:0]}
                    + {{NIBBLE{1'b0}}, c_eff};
            sum   = full[WIDTH-1:0];
            c_out = full[WIDTH] ^ sub;
            h_out = low[NIBBLE] ^ sub;
         end
      end else begin : g_direct
         logic [WIDTH:0]  full;
         logic [NIBBLE:0] low;

         always_comb begin
            if (sub) begin
               full = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cin};
               low  = {1'b0, a[NIBBLE-1:0]} - {1'b0, b[NIBBLE-1:0]}
                      - {{NIBBLE{1'b0}}, cin};
            end else begin
               full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
               low  = {1'b0, a[NIBBLE-1:0]} + {1'b0, b[NIBBLE-1:0]}
                      + {{NIBBLE{1'b0}}, cin};
            end
            sum   = full[WIDTH-1:0];
            c_out = full[WIDTH];
            h_out = low[NIBBLE];
         end
      end
   endgenerate

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic_sel_e       sel,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      case (sel)
         LG_AND:  y = a & b;
         LG_XOR:  y = a ^ b;
         LG_OR:   y = a | b;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/acc_alu_wide.sv
module acc_alu_wide #(
   parameter int WIDTH  = 8,
   parameter int NIBBLE = 4
) (
   input  logic [2*WIDTH-1:0] wa,
   input  logic [2*WIDTH-1:0] wb,
   input  logic [WIDTH-1:0]   offset,
   input  logic               use_offset,
   output logic [2*WIDTH-1:0] wsum,
   output logic               h_out,
   output logic               c_out
);

   localparam int WW    = 2 * WIDTH;
   localparam int HIGHH = WW - NIBBLE;   // pair half-carry taken below the top nibble

   logic [WW:0]      pair_full;
   logic [HIGHH:0]   pair_part;
   logic [WW-1:0]    off_ext;
   logic [WW-1:0]    off_sum;
   logic [WIDTH:0]   off_byte;
   logic [NIBBLE:0]  off_nib;

   always_comb begin
      pair_full = {1'b0, wa} + {1'b0, wb};
      pair_part = {1'b0, wa[HIGHH-1:0]} + {1'b0, wb[HIGHH-1:0]};

      off_ext   = {{WIDTH{offset[WIDTH-1]}}, offset};
      off_sum   = wa + off_ext;
      off_byte  = {1'b0, wa[WIDTH-1:0]} + {1'b0, offset};
      off_nib   = {1'b0, wa[NIBBLE-1:0]} + {1'b0, offset[NIBBLE-1:0]};

      if (use_offset) begin
         wsum  = off_sum;
         h_out = off_nib[NIBBLE];
         c_out = off_byte[WIDTH];
      end else begin
         wsum  = pair_full[WW-1:0];
         h_out = pair_part[HIGHH];
         c_out = pair_full[WW];
      end
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH         = 8,
   parameter int NIBBLE        = 4,
   parameter bit SUB_BY_INVERT = 1'b1
) (
   input  logic [3:0]         op_sel,
   input  logic [WIDTH-1:0]   opnd_a,
   input  logic [WIDTH-1:0]   opnd_b,
   input  logic               carry_in,
   input  logic [2*WIDTH-1:0] pair_a,
   input  logic [2*WIDTH-1:0] pair_b,
   output logic [WIDTH-1:0]   result,
   output logic               result_we,
   output logic [2*WIDTH-1:0] pair_result,
   output logic               pair_we,
   output logic               flag_z,
   output logic               flag_n,
   output logic               flag_h,
   output logic               flag_c,
   output logic               wr_z,
   output logic               wr_n,
   output logic               wr_h,
   output logic               wr_c
);

   localparam int WW = 2 * WIDTH;

   generate
      if (WIDTH < 8 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("acc_alu: WIDTH must be even and at least 8");
      end
      if (NIBBLE < 1 || NIBBLE >= WIDTH) begin : g_bad_nibble
         $error("acc_alu: NIBBLE must lie between 1 and WIDTH-1");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] as_b;
   logic             as_cin;
   logic             as_sub;
   logic [WIDTH-1:0] as_sum;
   logic             as_c;
   logic             as_h;
   logic             as_zero;
   logic_sel_e       lg_sel;
   logic [WIDTH-1:0] lg_y;
   logic             lg_zero;
   logic [WW-1:0]    wd_sum;
   logic             wd_h;
   logic             wd_c;
   alu_flags_t       fval;
   alu_flags_t       fwe;

   assign op = alu_op_e'(op_sel);

   // operand steering for the shared byte adder
   always_comb begin
      as_b   = opnd_b;
      as_cin = 1'b0;
      as_sub = 1'b0;
      lg_sel = LG_AND;
      case (op)
         OP_ADC:  as_cin = carry_in;
         OP_SUB:  as_sub = 1'b1;
         OP_SBC:  begin as_sub = 1'b1; as_cin = carry_in; end
         OP_CMP:  as_sub = 1'b1;
         OP_INC:  as_b = WIDTH'(1);
         OP_DEC:  begin as_b = WIDTH'(1); as_sub = 1'b1; end
         OP_XOR:  lg_sel = LG_XOR;
         OP_OR:   lg_sel = LG_OR;
         default: ;
      endcase
   end

   acc_alu_addsub #(
      .WIDTH         (WIDTH),
      .NIBBLE        (NIBBLE),
      .SUB_BY_INVERT (SUB_BY_INVERT)
   ) u_addsub (
      .a     (opnd_a),
      .b     (as_b),
      .cin   (as_cin),
      .sub   (as_sub),
      .sum   (as_sum),
      .c_out (as_c),
      .h_out (as_h)
   );

   acc_alu_logic #(
      .WIDTH (WIDTH)
   ) u_logic (
      .a   (opnd_a),
      .b   (opnd_b),
      .sel (lg_sel),
      .y   (lg_y)
   );

   acc_alu_wide #(
      .WIDTH  (WIDTH),
      .NIBBLE (NIBBLE)
   ) u_wide (
      .wa         (pair_a),
      .wb         (pair_b),
      .offset     (opnd_b),
      .use_offset (op == OP_ADDSP),
      .wsum       (wd_sum),
      .h_out      (wd_h),
      .c_out      (wd_c)
   );

   assign as_zero = (as_sum == '0);
   assign lg_zero = (lg_y == '0);

   // result selection and per-operation flag policy
   always_comb begin
      result      = opnd_a;
      result_we   = 1'b0;
      pair_result = pair_a;
      pair_we     = 1'b0;
      fval        = '0;
      fwe         = '0;
      case (op)
         OP_ADD, OP_ADC: begin
            result    = as_sum;
            result_we = 1'b1;
            fval      = '{z: as_zero, n: 1'b0, h: as_h, c: as_c};
            fwe       = '1;
         end
         OP_SUB, OP_SBC: begin
            result    = as_sum;
            result_we = 1'b1;
            fval      = '{z: as_zero, n: 1'b1, h: as_h, c: as_c};
            fwe       = '1;
         end
         OP_CMP: begin
            fval      = '{z: as_zero, n: 1'b1, h: as_h, c: as_c};
            fwe       = '1;
         end
         OP_AND: begin
            result    = lg_y;
            result_we = 1'b1;
            fval      = '{z: lg_zero, n: 1'b0, h: 1'b1, c: 1'b0};
            fwe       = '1;
         end
         OP_XOR, OP_OR: begin
            result    = lg_y;
            result_we = 1'b1;
            fval      = '{z: lg_zero, n: 1'b0, h: 1'b0, c: 1'b0};
            fwe       = '1;
         end
         OP_INC, OP_DEC: begin
            result    = as_sum;
            result_we = 1'b1;
            fval      = '{z: as_zero, n: as_sub, h: as_h, c: 1'b0};
            fwe       = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b0};
         end
         OP_ADDW: begin
            pair_result = wd_sum;
            pair_we     = 1'b1;
            fval        = '{z: 1'b0, n: 1'b0, h: wd_h, c: wd_c};
            fwe         = '{z: 1'b0, n: 1'b1, h: 1'b1, c: 1'b1};
         end
         OP_ADDSP: begin
            pair_result = wd_sum;
            pair_we     = 1'b1;
            fval        = '{z: 1'b0, n: 1'b0, h: wd_h, c: wd_c};
            fwe         = '1;
         end
         default: ;
      endcase
   end

   assign flag_z = fval.z;
   assign flag_n = fval.n;
   assign flag_h = fval.h;
   assign flag_c = fval.c;
   assign wr_z   = fwe.z;
   assign wr_n   = fwe.n;
   assign wr_h   = fwe.h;
   assign wr_c   = fwe.c;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int WIDTH = 8
) (
   input logic [3:0]         op_sel,
   input logic [WIDTH-1:0]   opnd_a,
   input logic [2*WIDTH-1:0] pair_a,
   input logic [WIDTH-1:0]   result,
   input logic               result_we,
   input logic [2*WIDTH-1:0] pair_result,
   input logic               pair_we,
   input logic               flag_z,
   input logic               flag_n,
   input logic               flag_h,
   input logic               flag_c,
   input logic               wr_z,
   input logic               wr_n,
   input logic               wr_h,
   input logic               wr_c
);

   always_comb begin
      if (op_sel == 4'd7) begin
         p_cmp_no_write_r3: assert (!result_we && result == opnd_a && flag_n && wr_c)
            else $error("compare wrote the accumulator or lost its flags");
      end
      if (op_sel == 4'd4) begin
         p_and_half_set_r4: assert (flag_h && !flag_n && !flag_c)
            else $error("AND flag policy broken");
      end
      if (op_sel == 4'd8 || op_sel == 4'd9) begin
         p_incdec_keep_c_r6: assert (!wr_c && wr_z && wr_h)
            else $error("increment/decrement touched carry enable");
      end
      if (op_sel == 4'd10) begin
         p_pair_keep_z_r7: assert (!wr_z && pair_we && !flag_n)
            else $error("pair add touched zero enable");
      end
      if (op_sel == 4'd11) begin
         p_offset_zn_clear_r8: assert (!flag_z && !flag_n && wr_z && wr_n)
            else $error("offset add did not clear zero and subtract");
      end
      if (op_sel >= 4'd12) begin
         p_unused_quiet_r9: assert (!result_we && !pair_we && !wr_z && !wr_n && !wr_h && !wr_c
                                    && result == opnd_a && pair_result == pair_a)
            else $error("unused code requested a write");
      end
      p_we_exclusive_r10: assert (!(result_we && pair_we))
         else $error("byte and pair writes both requested");
      p_masked_flags_zero_r10: assert ((wr_z || !flag_z) && (wr_n || !flag_n)
                                       && (wr_h || !flag_h) && (wr_c || !flag_c))
         else $error("flag value set with its enable low");
      if (result_we && wr_z) begin
         p_zero_tracks_result_r1: assert (flag_z == (result == '0))
            else $error("zero flag disagrees with written result");
      end
   end

endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_acc_alu_chk (
   .op_sel      (op_sel),
   .opnd_a      (opnd_a),
   .pair_a      (pair_a),
   .result      (result),
   .result_we   (result_we),
   .pair_result (pair_result),
   .pair_we     (pair_we),
   .flag_z      (flag_z),
   .flag_n      (flag_n),
   .flag_h      (flag_h),
   .flag_c      (flag_c),
   .wr_z        (wr_z),
   .wr_n        (wr_n),
   .wr_h        (wr_h),
   .wr_c        (wr_c)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;

   localparam int W = 8;

   typedef struct packed {
      logic [3:0]   op;
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         cin;
      logic [15:0]  pa;
      logic [15:0]  pb;
   } stim_t;

   typedef struct packed {
      logic [W-1:0] res;
      logic         res_we;
      logic [15:0]  pres;
      logic         p_we;
      logic [3:0]   fl;   // z n h c
      logic [3:0]   we;   // z n h c
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   stim_t cur = '0;
   stim_t stim_q[$];
   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    fails  = 0;
   bit    finished = 1'b0;

   logic [W-1:0]  d_res [2];
   logic          d_rwe [2];
   logic [15:0]   d_pres[2];
   logic          d_pwe [2];
   logic [3:0]    d_fl  [2];
   logic [3:0]    d_we  [2];

   acc_alu #(.WIDTH(W), .SUB_BY_INVERT(1'b1)) i_acc_alu (
      .op_sel (cur.op), .opnd_a (cur.a), .opnd_b (cur.b), .carry_in (cur.cin),
      .pair_a (cur.pa), .pair_b (cur.pb),
      .result (d_res[0]), .result_we (d_rwe[0]), .pair_result (d_pres[0]), .pair_we (d_pwe[0]),
      .flag_z (d_fl[0][3]), .flag_n (d_fl[0][2]), .flag_h (d_fl[0][1]), .flag_c (d_fl[0][0]),
      .wr_z (d_we[0][3]), .wr_n (d_we[0][2]), .wr_h (d_we[0][1]), .wr_c (d_we[0][0])
   );

   acc_alu #(.WIDTH(W), .SUB_BY_INVERT(1'b0)) i_acc_alu_direct (
      .op_sel (cur.op), .opnd_a (cur.a), .opnd_b (cur.b), .carry_in (cur.cin),
      .pair_a (cur.pa), .pair_b (cur.pb),
      .result (d_res[1]), .result_we (d_rwe[1]), .pair_result (d_pres[1]), .pair_we (d_pwe[1]),
      .flag_z (d_fl[1][3]), .flag_n (d_fl[1][2]), .flag_h (d_fl[1][1]), .flag_c (d_fl[1][0]),
      .wr_z (d_we[1][3]), .wr_n (d_we[1][2]), .wr_h (d_we[1][1]), .wr_c (d_we[1][0])
   );

   function automatic exp_t model(stim_t s);
      exp_t e;
      int   a, b, c, r, d;
      a = int'(s.a);
      b = int'(s.b);
      e.res = s.a; e.res_we = 1'b0; e.pres = s.pa; e.p_we = 1'b0;
      e.fl = 4'b0000; e.we = 4'b0000;
      case (s.op)
         4'd0, 4'd1: begin
            c = (s.op == 4'd1) ? int'(s.cin) : 0;
            r = a + b + c;
            e.res = r[7:0]; e.res_we = 1'b1; e.we = 4'b1111;
            e.fl = {r[7:0] == 8'h00, 1'b0, ((a & 15) + (b & 15) + c) > 15, r > 255};
         end
         4'd2, 4'd3, 4'd7: begin
            c = (s.op == 4'd3) ? int'(s.cin) : 0;
            d = a - b - c;
            r = d & 255;
            e.we = 4'b1111;
            if (s.op != 4'd7) begin e.res = r[7:0]; e.res_we = 1'b1; end
            e.fl = {r == 0, 1'b1, ((a & 15) - (b & 15) - c) < 0, d < 0};
         end
         4'd4, 4'd5, 4'd6: begin
            r = (s.op == 4'd4) ? (a & b) : (s.op == 4'd5) ? (a ^ b) : (a | b);
            e.res = r[7:0]; e.res_we = 1'b1; e.we = 4'b1111;
            e.fl = {r == 0, 1'b0, s.op == 4'd4, 1'b0};
         end
         4'd8: begin
            r = (a + 1) & 255;
            e.res = r[7:0]; e.res_we = 1'b1; e.we = 4'b1110;
            e.fl = {r == 0, 1'b0, (a & 15) == 15, 1'b0};
         end
         4'd9: begin
            r = (a + 255) & 255;
            e.res = r[7:0]; e.res_we = 1'b1; e.we = 4'b1110;
            e.fl = {r == 0, 1'b1, (a & 15) == 0, 1'b0};
         end
         4'd10: begin
            r = int'(s.pa) + int'(s.pb);
            e.pres = r[15:0]; e.p_we = 1'b1; e.we = 4'b0111;
            e.fl = {1'b0, 1'b0, ((int'(s.pa) & 4095) + (int'(s.pb) & 4095)) > 4095, r > 65535};
         end
         4'd11: begin
            d = (b > 127) ? b - 256 : b;
            r = (int'(s.pa) + d) & 65535;
            e.pres = r[15:0]; e.p_we = 1'b1; e.we = 4'b1111;
            e.fl = {1'b0, 1'b0, ((int'(s.pa) & 15) + (b & 15)) > 15,
                    ((int'(s.pa) & 255) + b) > 255};
         end
         default: ;
      endcase
      return e;
   endfunction

   function automatic string req_of(logic [3:0] op);
      case (op)
         4'd0, 4'd1:         return "R1";
         4'd2, 4'd3:         return "R2";
         4'd7:               return "R3";
         4'd4:               return "R4";
         4'd5, 4'd6:         return "R5";
         4'd8, 4'd9:         return "R6";
         4'd10:              return "R7";
         4'd11:              return "R8";
         default:            return "R9";
      endcase
   endfunction

   // driver: apply one stimulus per clock and queue what must come out
   task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic cin, input logic [15:0] pa, input logic [15:0] pb);
      stim_t s;
      @(posedge clk);
      s = '{op: op, a: a, b: b, cin: cin, pa: pa, pb: pb};
      cur = s;
      exp_q.push_back(model(s));
      tag_q.push_back(req_of(op));
      stim_q.push_back(s);
   endtask

   // monitor: compare half a period later, both subtractor variants
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t  e;
         stim_t s;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         s = stim_q.pop_front();
         for (int v = 0; v < 2; v++) begin
            checks++;
            if (d_res[v] !== e.res || d_rwe[v] !== e.res_we || d_pres[v] !== e.pres ||
                d_pwe[v] !== e.p_we || d_fl[v] !== e.fl || d_we[v] !== e.we) begin
               fails++;
               $display("FAIL %s (R10 masking) variant %0d op=%0d a=%h b=%h cin=%0b: actual res=%h/%0b pair=%h/%0b fl=%b we=%b expected res=%h/%0b pair=%h/%0b fl=%b we=%b",
                        t, v, s.op, s.a, s.b, s.cin, d_res[v], d_rwe[v], d_pres[v], d_pwe[v],
                        d_fl[v], d_we[v], e.res, e.res_we, e.pres, e.p_we, e.fl, e.we);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset-time idle state: code 0 with zero operands gives zero flag
      drive(4'd0, 8'h00, 8'h00, 1'b0, 16'h0000, 16'h0000);          // R1
      // R1 corners: nibble carry, byte carry with carry_in, wrap to zero
      drive(4'd0, 8'h0F, 8'h01, 1'b1, 16'h0, 16'h0);
      drive(4'd1, 8'hFF, 8'h00, 1'b1, 16'h0, 16'h0);
      drive(4'd1, 8'h07, 8'h08, 1'b1, 16'h0, 16'h0);
      // R2 corners: borrow-in across equal nibbles, full underflow
      drive(4'd2, 8'h10, 8'h01, 1'b1, 16'h0, 16'h0);
      drive(4'd3, 8'h00, 8'hFF, 1'b1, 16'h0, 16'h0);
      drive(4'd3, 8'h55, 8'h55, 1'b1, 16'h0, 16'h0);
      drive(4'd2, 8'h42, 8'h42, 1'b0, 16'h0, 16'h0);
      // R3 compare equal and less
      drive(4'd7, 8'h3C, 8'h3C, 1'b1, 16'h0, 16'h0);
      drive(4'd7, 8'h01, 8'h80, 1'b0, 16'h0, 16'h0);
      // R4 / R5 zero results
      drive(4'd4, 8'hF0, 8'h0F, 1'b1, 16'h0, 16'h0);
      drive(4'd5, 8'hA5, 8'hA5, 1'b1, 16'h0, 16'h0);
      drive(4'd6, 8'h00, 8'h00, 1'b1, 16'h0, 16'h0);
      // R6 nibble edges, carry_in must not matter
      drive(4'd8, 8'hFF, 8'h00, 1'b1, 16'h0, 16'h0);
      drive(4'd8, 8'h0F, 8'h00, 1'b0, 16'h0, 16'h0);
      drive(4'd9, 8'h00, 8'h00, 1'b1, 16'h0, 16'h0);
      drive(4'd9, 8'h01, 8'h00, 1'b1, 16'h0, 16'h0);
      // R7 pair wrap at bit 11 and bit 16
      drive(4'd10, 8'h12, 8'h34, 1'b0, 16'h0FFF, 16'h0001);
      drive(4'd10, 8'h12, 8'h34, 1'b1, 16'hFFFF, 16'h0001);
      // R8 negative and positive offsets
      drive(4'd11, 8'h00, 8'hFF, 1'b0, 16'h0001, 16'h0);
      drive(4'd11, 8'h00, 8'h80, 1'b1, 16'h0000, 16'h0);
      drive(4'd11, 8'h00, 8'h01, 1'b0, 16'h00FF, 16'h0);
      // R9 unused codes
      for (int k = 12; k < 16; k++)
         drive(4'(k), 8'hC3, 8'h5A, 1'b1, 16'hBEEF, 16'h1234);
      // random sweep across every code
      for (int n = 0; n < 3000; n++)
         drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 1'($urandom),
               16'($urandom), 16'($urandom));
      repeat (3) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule